// File: doc/BRIEF.md
# DMA Thread Wait-Condition Unit

This unit sits beside the instruction decoder of one DMA thread, which may be a manager thread or a channel thread. It recognises two 16-bit wait instructions. One waits for an event. The other waits for a peripheral request.

When a wait instruction is accepted, the unit stalls the thread until the selected condition is seen. It then issues a one-cycle resume pulse. A number that the configuration does not implement aborts the thread instead of waiting. A peripheral wait issued from the manager thread also aborts.

An event wait can carry a flag that requests invalidation of the thread's instruction cache. A stored request-type flag records whether the last peripheral wait finished as a single transfer or as a burst transfer.

The number of implemented events is set by the parameter `NumEvents`. The number of implemented peripherals is set by `NumPeriphs`. Both defaults are at most 32, because the immediate field is 5 bits wide.

Top module: `dma_wait_unit`

## Requirements
- R1: Instruction encoding:
  - Both wait instructions carry a 5-bit number in bits [15:11].
  - An event wait has bits [7:0] = 0x36, with bits 10 and 8 both 0. Bit 9 is the invalidate flag.
  - A peripheral wait has bits [7:2] = 6'b001100, with bits [10:8] all 0. Bit 1 is the peripheral-mode flag and bit 0 is the burst flag.
  - Any other word presented with the valid strobe is ignored: there is no stall, no abort and no invalidate.
- R2: `stall` rises in the cycle after an instruction is accepted without abort. It stays high until the cycle in which `resumePulse` is high, and falls in that same cycle.
- R3: An event wait resumes when `eventVec[number]` is high. If the event is already high at acceptance, `resumePulse` is high in the second cycle after acceptance. If the event arrives later, `resumePulse` is high in the cycle after it is first seen.
- R4: An event wait whose number is `NumEvents` or larger produces a one-cycle `abortPulse` in the cycle after acceptance, with no stall. An event wait is legal in both manager and channel threads.
- R5: An accepted event wait with the invalidate flag at 1 produces a one-cycle `icacheInvPulse` in the cycle after acceptance. This happens even if the instruction aborts. With the flag at 0, no invalidate pulse is produced.
- R6: A peripheral wait aborts, as described in R4, in either of two cases: its number is `NumPeriphs` or larger, or `isManager` is high.
- R7: Single mode is burst flag 0 and mode flag 0. Either request line of the selected peripheral resumes the thread, and `reqTypeBurst` becomes 0.
- R8: Burst mode is burst flag 1 and mode flag 0. Only the burst request resumes the thread: a single request alone keeps it stalled. `reqTypeBurst` becomes 1.
- R9: Peripheral mode is mode flag 1. Either request resumes the thread, and `reqTypeBurst` takes the type of the request received. If both requests are present, burst wins.
- R10: `resumePulse`, `abortPulse` and `icacheInvPulse` are each one cycle wide. Resume and abort are never high together.
- R11: A valid strobe while `stall` is high is ignored: it causes no abort, no invalidate and no change to the wait in progress.
- R12: `reqTypeBurst` resets to 0. It changes only when a peripheral wait resumes. Event waits and aborts leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word valid strobe |
| instrWord | input | 16 | Decoded wait instruction |
| isManager | input | 1 | High when the thread is the manager thread |
| eventVec | input | 32 | Event level inputs |
| periphSingleReq | input | 32 | Single request line for each peripheral |
| periphBurstReq | input | 32 | Burst request line for each peripheral |
| stall | output | 1 | Thread halted by a wait |
| resumePulse | output | 1 | One-cycle pulse when the wait completes |
| abortPulse | output | 1 | One-cycle pulse when the thread is aborted |
| icacheInvPulse | output | 1 | One-cycle instruction-cache invalidate request |
| reqTypeBurst | output | 1 | Stored request type, 1 for burst and 0 for single |

## Verification
A wrong captured number or mode would show at the ports within one cycle of the condition lines changing. The stall either fails to drop when the correct line rises, or it drops on a line that should not release it, such as a single request during a burst wait. A stuck wait state shows as `stall` staying high after the condition has already been applied, and a lost acceptance shows as `stall` staying low in the cycle after the strobe. A corrupted request-type register becomes visible in the cycle after the next peripheral resume, or immediately after any event wait, because that value must hold.

// File: rtl/dma_wait_pkg.sv
package dma_wait_pkg;
  localparam int LINES = 32;
  localparam int NUM_W = 5;

  localparam logic [7:0] OPC_EVT = 8'h36;
  localparam logic [5:0] OPC_PER = 6'b001100;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_PERIPH = 2'd2
  } waitMode_e;

  typedef struct packed {
    logic capture;     // latch the instruction fields and start waiting
    logic commitType;  // wait completes in this cycle
  } ctlStrobe_t;

  typedef struct packed {
    logic isEvt;
    logic isPer;
    logic badNum;
    logic invBit;
  } decodeInfo_t;
endpackage

// File: rtl/dma_wait_dp.sv
module dma_wait_dp
  import dma_wait_pkg::*;
#(
  parameter int NumEvents  = 8,
  parameter int NumPeriphs = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [15:0]         instrWord,
  input  logic                isManager,
  input  logic [LINES-1:0]    eventVec,
  input  logic [LINES-1:0]    periphSingleReq,
  input  logic [LINES-1:0]    periphBurstReq,
  input  ctlStrobe_t          strobe,
  output decodeInfo_t         decode,
  output logic                condMet,
  output logic                reqTypeBurst
);
  localparam logic [NUM_W:0] EVT_LIM = (NUM_W+1)'(NumEvents);
  localparam logic [NUM_W:0] PER_LIM = (NUM_W+1)'(NumPeriphs);

  logic [NUM_W-1:0] num;
  waitMode_e        newMode;
  logic [NUM_W-1:0] heldNum;
  logic             heldIsPer;
  waitMode_e        heldMode;
  logic             hitBurst;
  logic             hitSingle;

  // Field decode of the incoming word
  assign num = instrWord[15:11];

  always_comb begin
    decode.isEvt  = (instrWord[7:0] == OPC_EVT) && !instrWord[10] && !instrWord[8];
    decode.isPer  = (instrWord[7:2] == OPC_PER) && (instrWord[10:8] == 3'b000);
    decode.invBit = instrWord[9];
    if (decode.isEvt) decode.badNum = ({1'b0, num} >= EVT_LIM);
    else              decode.badNum = isManager || ({1'b0, num} >= PER_LIM);
  end

  always_comb begin
    if (instrWord[1])      newMode = MODE_PERIPH;
    else if (instrWord[0]) newMode = MODE_BURST;
    else                   newMode = MODE_SINGLE;
  end

  // Held fields of the wait in progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldNum   <= '0;
      heldIsPer <= 1'b0;
      heldMode  <= MODE_SINGLE;
    end else if (strobe.capture) begin
      heldNum   <= num;
      heldIsPer <= decode.isPer;
      heldMode  <= newMode;
    end
  end

  assign hitBurst  = periphBurstReq[heldNum];
  assign hitSingle = periphSingleReq[heldNum];

  always_comb begin
    if (!heldIsPer)                    condMet = eventVec[heldNum];
    else if (heldMode == MODE_BURST)   condMet = hitBurst;
    else                               condMet = hitBurst || hitSingle;
  end

  // Stored request type
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTypeBurst <= 1'b0;
    end else if (strobe.commitType && heldIsPer) begin
      case (heldMode)
        MODE_SINGLE: reqTypeBurst <= 1'b0;
        MODE_BURST:  reqTypeBurst <= 1'b1;
        MODE_PERIPH: reqTypeBurst <= hitBurst;
        default:     reqTypeBurst <= reqTypeBurst;
      endcase
    end
  end

  assert_burst_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitType && heldIsPer && heldMode == MODE_BURST) |-> periphBurstReq[heldNum]);

  assert_burst_type_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitType && heldIsPer && heldMode == MODE_BURST) |=> reqTypeBurst);

  assert_burst_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitType && heldIsPer && heldMode == MODE_PERIPH && hitBurst) |=> reqTypeBurst);

  assert_type_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commitType && heldIsPer) |=> $stable(reqTypeBurst));
endmodule

// File: rtl/dma_wait_ctl.sv
module dma_wait_ctl
  import dma_wait_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  decodeInfo_t decode,
  input  logic        condMet,
  output ctlStrobe_t  strobe,
  output logic        stall,
  output logic        resumePulse,
  output logic        abortPulse,
  output logic        icacheInvPulse
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e state, stateNext;
  logic   accept;

  assign accept = instrValid && (state == ST_IDLE) && (decode.isEvt || decode.isPer);

  always_comb begin
    strobe.capture    = accept && !decode.badNum;
    strobe.commitType = (state == ST_WAIT) && condMet;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.capture)    stateNext = ST_WAIT;
      ST_WAIT: if (strobe.commitType) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      resumePulse    <= 1'b0;
      abortPulse     <= 1'b0;
      icacheInvPulse <= 1'b0;
    end else begin
      state          <= stateNext;
      resumePulse    <= strobe.commitType;
      abortPulse     <= accept && decode.badNum;
      icacheInvPulse <= accept && decode.isEvt && decode.invBit;
    end
  end

  assign stall = (state == ST_WAIT);

  assert_stall_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> resumePulse);

  assert_resume_after_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumePulse) |-> !stall);

  assert_abort_no_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !stall);

  assert_resume_width_R10: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse);

  assert_abort_width_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  assert_inv_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    icacheInvPulse |=> !icacheInvPulse);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(resumePulse && abortPulse));

  assert_ignore_stalled_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stall && instrValid) |=> (!abortPulse && !icacheInvPulse));
endmodule

// File: rtl/dma_wait_unit.sv
module dma_wait_unit
  import dma_wait_pkg::*;
#(
  parameter int NumEvents  = 8,
  parameter int NumPeriphs = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  input  logic        isManager,
  input  logic [31:0] eventVec,
  input  logic [31:0] periphSingleReq,
  input  logic [31:0] periphBurstReq,
  output logic        stall,
  output logic        resumePulse,
  output logic        abortPulse,
  output logic        icacheInvPulse,
  output logic        reqTypeBurst
);
  ctlStrobe_t  strobe;
  decodeInfo_t decode;
  logic        condMet;

  initial begin
    if (NumEvents < 1 || NumEvents > LINES)   $error("NumEvents out of range");
    if (NumPeriphs < 1 || NumPeriphs > LINES) $error("NumPeriphs out of range");
  end

  dma_wait_dp #(
    .NumEvents (NumEvents),
    .NumPeriphs(NumPeriphs)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .instrWord      (instrWord),
    .isManager      (isManager),
    .eventVec       (eventVec),
    .periphSingleReq(periphSingleReq),
    .periphBurstReq (periphBurstReq),
    .strobe         (strobe),
    .decode         (decode),
    .condMet        (condMet),
    .reqTypeBurst   (reqTypeBurst)
  );

  dma_wait_ctl ctl_i (
    .clk           (clk),
    .rstN          (rstN),
    .instrValid    (instrValid),
    .decode        (decode),
    .condMet       (condMet),
    .strobe        (strobe),
    .stall         (stall),
    .resumePulse   (resumePulse),
    .abortPulse    (abortPulse),
    .icacheInvPulse(icacheInvPulse)
  );
endmodule

// File: tb/dma_wait_unit_tb.sv
`timescale 1ns/100ps
module dma_wait_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        isManager = 1'b0;
  logic [31:0] eventVec = '0;
  logic [31:0] periphSingleReq = '0;
  logic [31:0] periphBurstReq = '0;
  logic        stall, resumePulse, abortPulse, icacheInvPulse, reqTypeBurst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_wait_unit #(.NumEvents(8), .NumPeriphs(16)) dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .isManager(isManager), .eventVec(eventVec), .periphSingleReq(periphSingleReq),
    .periphBurstReq(periphBurstReq), .stall(stall), .resumePulse(resumePulse),
    .abortPulse(abortPulse), .icacheInvPulse(icacheInvPulse), .reqTypeBurst(reqTypeBurst)
  );

  typedef struct packed {
    logic [15:0] word;
    logic        mgr;
    logic [31:0] ev;
    logic [31:0] sg;
    logic [31:0] bu;
    logic        expAbort;
    logic        expInv;
    logic        expType;
  } vec_t;

  // Words: event = num<<11 | inv<<9 | 0x36; peripheral = num<<11 | 0x30 | p<<1 | bs
  localparam vec_t VECS [14] = '{
    '{16'h1836, 1'b0, 32'h8,        32'h0,     32'h0,      1'b0, 1'b0, 1'b0}, // evt 3
    '{16'h3A36, 1'b0, 32'h80,       32'h0,     32'h0,      1'b0, 1'b1, 1'b0}, // evt 7 inv
    '{16'h4236, 1'b0, 32'h100,      32'h0,     32'h0,      1'b1, 1'b1, 1'b0}, // evt 8 bad, inv
    '{16'h2830, 1'b0, 32'h0,        32'h0,     32'h20,     1'b0, 1'b0, 1'b0}, // per 5 single
    '{16'h2831, 1'b0, 32'h0,        32'h0,     32'h20,     1'b0, 1'b0, 1'b1}, // per 5 burst
    '{16'h0036, 1'b0, 32'h1,        32'h0,     32'h0,      1'b0, 1'b0, 1'b1}, // evt 0 holds type
    '{16'h1030, 1'b0, 32'h0,        32'h4,     32'h0,      1'b0, 1'b0, 1'b0}, // per 2 single
    '{16'h4832, 1'b0, 32'h0,        32'h200,   32'h200,    1'b0, 1'b0, 1'b1}, // per 9 periph both
    '{16'h4832, 1'b0, 32'h0,        32'h200,   32'h0,      1'b0, 1'b0, 1'b0}, // per 9 periph single
    '{16'h8030, 1'b0, 32'h0,        32'h0,     32'h10000,  1'b1, 1'b0, 1'b0}, // per 16 bad
    '{16'h0830, 1'b1, 32'h0,        32'h2,     32'h0,      1'b1, 1'b0, 1'b0}, // per 1 manager
    '{16'hF836, 1'b0, 32'h80000000, 32'h0,     32'h0,      1'b1, 1'b0, 1'b0}, // evt 31 bad
    '{16'h7831, 1'b0, 32'h0,        32'h0,     32'h8000,   1'b0, 1'b0, 1'b1}, // per 15 burst
    '{16'h1036, 1'b1, 32'h4,        32'h0,     32'h0,      1'b0, 1'b0, 1'b1}  // evt 2 manager
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    instrWord  = w;
    instrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic clearLines();
    eventVec = '0; periphSingleReq = '0; periphBurstReq = '0; isManager = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset reqType", reqTypeBurst, 0);
    chk("R2 reset stall", stall, 0);
    chk("R10 reset pulses", {resumePulse, abortPulse, icacheInvPulse}, 0);

    for (int k = 0; k < 14; k++) begin
      isManager = VECS[k].mgr;
      eventVec = VECS[k].ev;
      periphSingleReq = VECS[k].sg;
      periphBurstReq = VECS[k].bu;
      issue(VECS[k].word);
      chk("R4 R6 abort", abortPulse, VECS[k].expAbort);
      chk("R5 invalidate", icacheInvPulse, VECS[k].expInv);
      chk("R2 stall after accept", stall, !VECS[k].expAbort);
      @(negedge clk);
      chk("R1 R3 R7 R8 R9 resume", resumePulse, !VECS[k].expAbort);
      chk("R2 stall dropped", stall, 0);
      chk("R10 abort width", abortPulse, 0);
      chk("R5 invalidate width", icacheInvPulse, 0);
      chk("R7 R8 R9 R12 reqType", reqTypeBurst, VECS[k].expType);
      clearLines();
      @(negedge clk);
      chk("R10 resume width", resumePulse, 0);
    end

    // R8: burst wait on peripheral 4 with only a single request
    periphSingleReq = 32'h10;
    issue(16'h2031);
    repeat (4) @(negedge clk);
    chk("R8 single does not release", stall, 1);
    chk("R8 no resume", resumePulse, 0);
    // R11: bad event word while stalled is ignored
    issue(16'hFA36);
    chk("R11 no abort", abortPulse, 0);
    chk("R11 no invalidate", icacheInvPulse, 0);
    chk("R11 still stalled", stall, 1);
    periphBurstReq = 32'h10;
    @(negedge clk);
    chk("R8 burst releases", resumePulse, 1);
    chk("R8 type burst", reqTypeBurst, 1);
    clearLines();
    @(negedge clk);

    // R3: event arrives late
    issue(16'h2836);
    repeat (3) @(negedge clk);
    chk("R3 waits for event", stall, 1);
    eventVec = 32'h20;
    @(negedge clk);
    chk("R3 late event resume", resumePulse, 1);
    chk("R3 stall low", stall, 0);
    chk("R12 type held by event", reqTypeBurst, 1);
    clearLines();
    @(negedge clk);

    // R1: unknown opcode and reserved bit set are ignored
    eventVec = 32'hFFFF_FFFF;
    issue(16'h0000);
    chk("R1 unknown opcode no stall", stall, 0);
    chk("R1 unknown opcode no abort", abortPulse, 0);
    issue(16'h0436);
    chk("R1 reserved bit no stall", stall, 0);
    @(negedge clk);
    chk("R1 reserved bit no resume", resumePulse, 0);
    clearLines();

    // R9: periph mode late single request sets single type
    issue(16'h1832);
    @(negedge clk);
    chk("R9 waiting", stall, 1);
    periphSingleReq = 32'h8;
    @(negedge clk);
    chk("R9 single resume", resumePulse, 1);
    chk("R9 type single", reqTypeBurst, 0);
    clearLines();
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule